// File: doc/BRIEF.md
# Scaled 48-bit Real-Time Counter

This block keeps a 48-bit time count for an always-on power domain. The count goes up by one on every pulse of a slow timebase strobe (nominally 31250 Hz, given as a one-cycle `tick` in the fast bus clock domain) while counting is enabled. Software reaches the block through a simple 32-bit register port. It can read the count as a low word and a high half-word, and it can load a new count. It also programs a compare value.

A 4-bit scale picks a 32-bit window of the count: the count shifted right by the scale and then cut to 32 bits. When that window is at or above the compare value, a pending flag is set, and the interrupt output follows it. Software moves the count or the compare value to clear the flag. The register port is plain control. Each access is one cycle wide, it is never stalled, and read data is combinational from the current address. There is no stream interface, so there is no back-pressure to handle.

Top module: `scaled_rtc`

## Requirements
- R1: After reset the count is 0, scale is 0, counting is disabled, the compare register is 0xFFFFFFFF and `irq` is low.
- R2: Byte offsets: control 0x40, count low 0x48, count high 0x4C, compare 0x60. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: Reading 0x48 returns count bits 31:0. Reading 0x4C returns count bits 47:32 in bits 15:0, with bits 31:16 reading 0.
- R4: A write to 0x48 only stages a low word, and the count keeps running. A write to 0x4C loads bits 15:0 of the written data as the high half in the next cycle. The low half comes from the staged word if one is pending, or else from the current count. The staged word is then used up.
- R5: With control bit 12 set, each cycle with `tick` high adds one to the count. With bit 12 clear, `tick` has no effect.
- R6: The count wraps from 0xFFFF_FFFF_FFFF to 0.
- R7: Control bits 3:0 hold the scale. The pending flag (control bit 28, read-only) is 1 exactly when bits [scale+31:scale] of the count, with bits above 47 taken as 0, are at least the compare value. `irq` equals the flag.
- R8: Writing control bit 28 has no effect on the flag. Other control bits apart from 3:0 and 12 read 0.
- R9: A high-word load in a cycle where `tick` is high takes the loaded value, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Compare interrupt, equal to the pending flag |

## Verification
A write or a tick updates a register on the clock edge where it is presented. From then on, the count, the read data and `irq` show the new value, so each result is due one cycle after its stimulus. `bus_rdata` follows the address with no register in between. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge. It compares `irq` on the next falling edge and reads registers a moment after placing the address, so every sample falls on the cycle where its result is due.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h40;
  localparam logic [7:0] OFS_CNTLO = 8'h48;
  localparam logic [7:0] OFS_CNTHI = 8'h4C;
  localparam logic [7:0] OFS_CMP   = 8'h60;

  localparam int unsigned CTRL_RUN_BIT  = 12;
  localparam int unsigned CTRL_FLAG_BIT = 28;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_CNTLO,
    RSEL_CNTHI,
    RSEL_CMP
  } rsel_e;
endpackage

// File: rtl/srtc_decode.sv
module srtc_decode
  import srtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             rsel,
  output logic              wr_ctrl,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_cmp
);
  always_comb begin
    rsel = RSEL_NONE;
    if (sel) begin
      if (addr == ADDR_W'(OFS_CTRL))       rsel = RSEL_CTRL;
      else if (addr == ADDR_W'(OFS_CNTLO)) rsel = RSEL_CNTLO;
      else if (addr == ADDR_W'(OFS_CNTHI)) rsel = RSEL_CNTHI;
      else if (addr == ADDR_W'(OFS_CMP))   rsel = RSEL_CMP;
    end
  end

  assign wr_ctrl = wr && (rsel == RSEL_CTRL);
  assign wr_lo   = wr && (rsel == RSEL_CNTLO);
  assign wr_hi   = wr && (rsel == RSEL_CNTHI);
  assign wr_cmp  = wr && (rsel == RSEL_CMP);
endmodule

// File: rtl/srtc_counter.sv
module srtc_counter #(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] stage_q;
  logic              stage_v;
  logic              advance;
  logic [DATA_W-1:0] low_src;

  assign advance = run && tick && !wr_hi;
  assign low_src = stage_v ? stage_q : count[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      stage_q <= '0;
      stage_v <= 1'b0;
    end else begin
      if (wr_hi) begin
        count   <= {wdata[HI_W-1:0], low_src};
        stage_v <= 1'b0;
      end else begin
        if (advance) count <= count + CNT_W'(1);
        if (wr_lo) begin
          stage_q <= wdata;
          stage_v <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hi) |=> $stable(count)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_hi) |=> (count == $past(count) + CNT_W'(1))); // R5
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (count[CNT_W-1:DATA_W] == $past(wdata[HI_W-1:0]))); // R4
  AST_LO_STAGED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !(run && tick)) |=> $stable(count)); // R4
endmodule

// File: rtl/srtc_compare.sv
module srtc_compare #(
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DATA_W-1:0]  cmp,
  output logic               hit
);
  localparam int NVIEW = 1 << SCALE_W;

  logic [DATA_W-1:0] view [NVIEW];

  for (genvar s = 0; s < NVIEW; s++) begin : g_view
    assign view[s] = DATA_W'(count >> s);
  end

  assign hit = (view[scale] >= cmp);
endmodule

// File: rtl/scaled_rtc.sv
module scaled_rtc
  import srtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 48,
  parameter int SCALE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;

  rsel_e               rsel;
  logic                wr_ctrl, wr_lo, wr_hi, wr_cmp;
  logic [SCALE_W-1:0]  scale_q;
  logic                run_q;
  logic [DATA_W-1:0]   cmp_q;
  logic [CNT_W-1:0]    count;
  logic                hit;
  logic [DATA_W-1:0]   ctrl_view;

  srtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .rsel(rsel),
    .wr_ctrl(wr_ctrl), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_cmp(wr_cmp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      run_q   <= 1'b0;
      cmp_q   <= '1;
    end else begin
      if (wr_ctrl) begin
        scale_q <= bus_wdata[SCALE_W-1:0];
        run_q   <= bus_wdata[CTRL_RUN_BIT];
      end
      if (wr_cmp) cmp_q <= bus_wdata;
    end
  end

  srtc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .count(count)
  );

  srtc_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_cmp (
    .count(count), .scale(scale_q), .cmp(cmp_q), .hit(hit)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[SCALE_W-1:0]   = scale_q;
    ctrl_view[CTRL_RUN_BIT]  = run_q;
    ctrl_view[CTRL_FLAG_BIT] = hit;
  end

  always_comb begin
    unique case (rsel)
      RSEL_CTRL:  bus_rdata = ctrl_view;
      RSEL_CNTLO: bus_rdata = count[DATA_W-1:0];
      RSEL_CNTHI: bus_rdata = {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
      RSEL_CMP:   bus_rdata = cmp_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = hit;

  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_CNTHI))
      |-> (bus_rdata[DATA_W-1:HI_W] == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && rsel == RSEL_NONE) |-> (bus_rdata == '0)); // R2
  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_CTRL))
      |-> (bus_rdata[CTRL_FLAG_BIT] == irq)); // R7
  AST_CMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> (cmp_q == $past(bus_wdata))); // R7
endmodule

// File: tb/sim_scaled_rtc.sv
module sim_scaled_rtc;
  logic        clk = 1'b0;
  logic        rst_n, tick, bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;

  scaled_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam longint unsigned MASK48 = 64'hFFFF_FFFF_FFFF;
  longint unsigned m_cnt, m_stage;
  bit              m_stv, m_run;
  int unsigned     m_scale;
  logic [31:0]     m_cmp;
  int              checks = 0, fails = 0;
  bit              done = 0;

  function automatic bit m_irq();
    longint unsigned v = (m_cnt >> m_scale) & 64'hFFFF_FFFF;
    return v >= longint'(m_cmp);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h40: begin r[3:0] = m_scale[3:0]; r[12] = m_run; r[28] = m_irq(); end
      8'h48: r = m_cnt[31:0];
      8'h4C: r = {16'h0, m_cnt[47:32]};
      8'h60: r = m_cmp;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit w, input logic [7:0] a,
                     input logic [31:0] d, input bit t);
    bit loaded = 0;
    bit run_old = m_run;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk);
    if (s && w) begin
      case (a)
        8'h40: begin m_scale = d[3:0]; m_run = d[12]; end
        8'h48: begin m_stage = d; m_stv = 1; end
        8'h4C: begin
          m_cnt = ({48'h0, d[15:0]} << 32) | (m_stv ? m_stage : (m_cnt & 64'hFFFF_FFFF));
          m_stv = 0; loaded = 1;
        end
        8'h60: m_cmp = d;
        default: ;
      endcase
    end
    if (!loaded && run_old && t) m_cnt = (m_cnt + 1) & MASK48;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick = 0;
    check("R7 irq", {31'h0, irq}, {31'h0, m_irq()});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h0, 32'h0, 1);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    check(req, bus_rdata, m_read(a));
    bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_cnt = 0; m_stage = 0; m_stv = 0; m_run = 0; m_scale = 0; m_cmp = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values, with literal expectations
    check("R1 irq", {31'h0, irq}, 32'h0);
    bus_sel = 1; bus_addr = 8'h60; #1; check("R1 cmp", bus_rdata, 32'hFFFF_FFFF);
    bus_addr = 8'h40; #1; check("R1 ctrl", bus_rdata, 32'h0);
    bus_addr = 8'h48; #1; check("R1 lo", bus_rdata, 32'h0);
    bus_sel = 0;
    rd("R1 hi", 8'h4C);
    rd("R2 unmapped", 8'h44);

    // R5 tick ignored while disabled
    ticks(3);
    rd("R5 disabled", 8'h48);
    wr(8'h40, 32'h0000_1000);
    ticks(5);
    rd("R5 counting", 8'h48);
    check("R5 count five", m_read(8'h48), 32'd5);

    // R8 flag bit not writable; other bits read zero
    wr(8'h40, 32'hFFFF_EFF0 | 32'h1000);
    rd("R8 ctrl", 8'h40);

    // R4 staged low word
    wr(8'h48, 32'hAABB_CCDD);
    rd("R4 lo not loaded yet", 8'h48);
    ticks(2);
    rd("R4 still counting", 8'h48);
    wr(8'h4C, 32'hFFF1_2345);
    rd("R3 hi masked", 8'h4C);
    rd("R4 lo from stage", 8'h48);
    bus_sel = 1; bus_addr = 8'h4C; #1; check("R3 hi literal", bus_rdata, 32'h0000_2345);
    bus_sel = 0;
    ticks(3);
    wr(8'h4C, 32'h0000_0007);
    rd("R4 hi without stage keeps low", 8'h48);
    rd("R4 hi value", 8'h4C);

    // R6 wrap
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h4C, 32'h0000_FFFF);
    rd("R6 all ones", 8'h4C);
    ticks(1);
    rd("R6 wrap lo", 8'h48);
    rd("R6 wrap hi", 8'h4C);

    // R9 load wins over tick
    wr(8'h48, 32'h0000_0100);
    cyc(1, 1, 8'h4C, 32'h0, 1);
    rd("R9 load over tick", 8'h48);

    // R7 compare with scale 4: count 0x100 -> view 0x10
    wr(8'h40, 32'h0000_0004);
    wr(8'h60, 32'h0000_0010);
    rd("R7 flag set", 8'h40);
    wr(8'h60, 32'h0000_0011);
    rd("R7 flag clear", 8'h40);
    wr(8'h40, 32'h0000_1004);
    ticks(16);
    rd("R7 flag after ticks", 8'h40);
    wr(8'h40, 32'h0000_000F);
    wr(8'h48, 32'h0);
    wr(8'h4C, 32'h0000_8000);
    wr(8'h60, 32'h0000_0001);
    rd("R7 scale 15 truncation", 8'h40);
    wr(8'h4C, 32'h0000_4000);
    wr(8'h60, 32'h8000_0000);
    rd("R7 scale 15 top bit", 8'h40);
    check("R7 irq literal", {31'h0, irq}, 32'h1);

    // R2 unmapped write ignored
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    rd("R2 ctrl", 8'h40);
    rd("R2 lo", 8'h48);
    rd("R2 hi", 8'h4C);
    rd("R2 cmp", 8'h60);
    rd("R2 unmapped read", 8'h64);
    ticks(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule